// File: doc/BRIEF.md
# Parallel I/O Port Pin Controller

This block controls one general-purpose I/O port of `N` pins. Five registers, each `N` bits wide, are written and read over a simple synchronous register port. Bit `i` of every register affects pin `i` only. A pin can serve as plain general-purpose I/O, or it can be handed to one of two dedicated peripheral functions. The block produces the pad output value and the pad output enable, and applies open-drain behaviour where it is selected.

On the input side, the block returns each pin's level to the data register read path. It also passes the level to the peripheral inputs. A peripheral input that is not currently routed to its pin sees a fixed per-bit default, which is set by a parameter.

A chip builds several ports from identical copies of this controller. Each copy sits between the pads and the peripherals and is configured by software.

Top module: `pio_port_ctrl`

## Requirements
- R1: Register address 0 holds the assignment bits, 1 the function-option bits, 2 the direction bits, 3 the open-drain bits and 4 the data bits. A write with `reg_we` high updates the addressed register on the next clock edge, and a read returns its contents. Addresses 5 to 7 read as zero, and writes to them change no register.
- R2: After reset every register is zero. As a result no pad is driven, and a read of address 4 returns the live pad levels.
- R3: `pad_oe[i]` can only be 1 when direction bit `i` is 1 (output).
- R4: When open-drain bit `i` is 1, `pad_out[i]` is 0. `pad_oe[i]` is then 1 only if the pin is an output and its drive value is 0, so a drive value of 1 leaves the pad floating.
- R5: With assignment bit `i` at 0 (general-purpose), the drive value of pin `i` is data bit `i`.
- R6: With assignment bit `i` at 1 (dedicated), the drive value is `func_a_out[i]` when option bit `i` is 0 and `func_b_out[i]` when it is 1.
- R7: `func_a_in[i]` equals `pad_in[i]` only when assignment is 1, option is 0 and direction is 0; otherwise it equals bit `i` of parameter `DFLT_A`. `func_b_in[i]` behaves the same way with option 1 and parameter `DFLT_B`.
- R8: A read of the data register returns the latched data bit for pins that are general-purpose outputs, and `pad_in` for every other pin.
- R9: Changing one bit of a control register changes the behaviour of that pin only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | N | Write data |
| reg_rdata | output | N | Read data for `reg_addr` (combinational) |
| pad_in | input | N | Level seen at each pad |
| pad_out | output | N | Value driven towards each pad |
| pad_oe | output | N | Pad output enable |
| func_a_out | input | N | Output of the first dedicated function |
| func_b_out | input | N | Output of the second dedicated function |
| func_a_in | output | N | Input to the first dedicated function |
| func_b_in | output | N | Input to the second dedicated function |

## Verification
The bench targets configurations where the registers differ from bit to bit, so that a mux keyed on the wrong register shows up as a wrong bit. Open-drain pins carrying a 1 are checked for a floating pad; a design that drives the 1 high fails this check. Peripheral inputs are checked against their defaults whenever the routing conditions are not all met, with a special case for output pins that are otherwise routed; a design that ignores direction would leak the pad level into these inputs. The data read is checked on a port mixing output and input pins; returning the latched value on input pins, or the pad level on output pins, fails the check.

// File: rtl/pio_port_pkg.sv
package pio_port_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        SEL_ASSIGN = 3'd0,
        SEL_OPTION = 3'd1,
        SEL_DIR    = 3'd2,
        SEL_OPENDR = 3'd3,
        SEL_DATA   = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/pio_port_regs.sv
module pio_port_regs
    import pio_port_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      pin_lvl,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      asg_q,
    output logic [N-1:0]      opt_q,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      odn_q,
    output logic [N-1:0]      dat_q
);
    typedef struct packed {
        logic [N-1:0] asg;
        logic [N-1:0] opt;
        logic [N-1:0] dir;
        logic [N-1:0] odn;
        logic [N-1:0] dat;
    } regs_t;

    regs_t        st_d, st_q;
    logic [N-1:0] gpo_mask;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (reg_sel_e'(addr))
                SEL_ASSIGN: st_d.asg = wdata;
                SEL_OPTION: st_d.opt = wdata;
                SEL_DIR:    st_d.dir = wdata;
                SEL_OPENDR: st_d.odn = wdata;
                SEL_DATA:   st_d.dat = wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign asg_q    = st_q.asg;
    assign opt_q    = st_q.opt;
    assign dir_q    = st_q.dir;
    assign odn_q    = st_q.odn;
    assign dat_q    = st_q.dat;
    assign gpo_mask = ~st_q.asg & st_q.dir;

    always_comb begin
        case (reg_sel_e'(addr))
            SEL_ASSIGN: rdata = st_q.asg;
            SEL_OPTION: rdata = st_q.opt;
            SEL_DIR:    rdata = st_q.dir;
            SEL_OPENDR: rdata = st_q.odn;
            SEL_DATA:   rdata = (st_q.dat & gpo_mask) | (pin_lvl & ~gpo_mask);
            default:    rdata = '0;
        endcase
    end

    AST_DIR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == SEL_DIR) |=> (dir_q == $past(wdata)))
        else $error("direction write lost"); // R1
    AST_BAD_ADDR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr > 3'd4) |=> $stable(st_q))
        else $error("write to unused address changed state"); // R1
endmodule

// File: rtl/pio_pin_mux.sv
module pio_pin_mux #(
    parameter int           N      = 8,
    parameter logic [N-1:0] DFLT_A = '0,
    parameter logic [N-1:0] DFLT_B = '0
) (
    input  logic [N-1:0] asg,
    input  logic [N-1:0] opt,
    input  logic [N-1:0] dir,
    input  logic [N-1:0] odn,
    input  logic [N-1:0] dat,
    input  logic [N-1:0] pad_in,
    input  logic [N-1:0] fa_out,
    input  logic [N-1:0] fb_out,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] pad_oe,
    output logic [N-1:0] fa_in,
    output logic [N-1:0] fb_in
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic drv_val;
        logic route_a, route_b;

        always_comb begin
            if (asg[i]) drv_val = opt[i] ? fb_out[i] : fa_out[i];
            else        drv_val = dat[i];
        end

        always_comb begin
            if (odn[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = dir[i] & ~drv_val;
            end else begin
                pad_out[i] = drv_val;
                pad_oe[i]  = dir[i];
            end
        end

        assign route_a  = asg[i] & ~opt[i] & ~dir[i];
        assign route_b  = asg[i] &  opt[i] & ~dir[i];
        assign fa_in[i] = route_a ? pad_in[i] : DFLT_A[i];
        assign fb_in[i] = route_b ? pad_in[i] : DFLT_B[i];
    end
endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
    import pio_port_pkg::*;
#(
    parameter int           N      = 8,
    parameter logic [N-1:0] DFLT_A = 8'hA5,
    parameter logic [N-1:0] DFLT_B = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [N-1:0]      reg_wdata,
    output logic [N-1:0]      reg_rdata,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_oe,
    input  logic [N-1:0]      func_a_out,
    input  logic [N-1:0]      func_b_out,
    output logic [N-1:0]      func_a_in,
    output logic [N-1:0]      func_b_in
);
    logic [N-1:0] asg_q, opt_q, dir_q, odn_q, dat_q;

    pio_port_regs #(.N(N)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .pin_lvl(pad_in), .rdata(reg_rdata),
        .asg_q(asg_q), .opt_q(opt_q), .dir_q(dir_q), .odn_q(odn_q), .dat_q(dat_q)
    );

    pio_pin_mux #(.N(N), .DFLT_A(DFLT_A), .DFLT_B(DFLT_B)) u_mux (
        .asg(asg_q), .opt(opt_q), .dir(dir_q), .odn(odn_q), .dat(dat_q),
        .pad_in(pad_in), .fa_out(func_a_out), .fb_out(func_b_out),
        .pad_out(pad_out), .pad_oe(pad_oe), .fa_in(func_a_in), .fb_in(func_b_in)
    );

    AST_OE_NEEDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q) == '0)
        else $error("pad driven on an input pin"); // R3
    AST_OPENDRAIN_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (odn_q & pad_out) == '0)
        else $error("open-drain pin drives high"); // R4
    AST_GPO_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ dat_q) & ~asg_q & dir_q & ~odn_q) == '0)
        else $error("general-purpose output differs from data"); // R5
    AST_UNROUTED_A_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((func_a_in ^ DFLT_A) & ~(asg_q & ~opt_q & ~dir_q)) == '0)
        else $error("unrouted input A not at default"); // R7
    AST_UNROUTED_B_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((func_b_in ^ DFLT_B) & ~(asg_q & opt_q & ~dir_q)) == '0)
        else $error("unrouted input B not at default"); // R7
endmodule

// File: tb/pio_port_ctrl_bench.sv
module pio_port_ctrl_bench;
    localparam int           N      = 8;
    localparam int           CLK_P  = 10;
    localparam logic [N-1:0] DFLT_A = 8'hA5;
    localparam logic [N-1:0] DFLT_B = 8'h3C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata, pad_in, pad_out, pad_oe;
    logic [N-1:0] func_a_out, func_b_out, func_a_in, func_b_in;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    pio_port_ctrl #(.N(N), .DFLT_A(DFLT_A), .DFLT_B(DFLT_B)) u_pio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .func_a_out(func_a_out),
        .func_b_out(func_b_out), .func_a_in(func_a_in), .func_b_in(func_b_in)
    );

    task automatic check(input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cfg(input logic [N-1:0] asg, opt, dir, odn, dat);
        wr(3'd0, asg); wr(3'd1, opt); wr(3'd2, dir); wr(3'd3, odn); wr(3'd4, dat);
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        pad_in = 8'h5A;
        for (int a = 0; a < 4; a++) begin
            rd(a[2:0], v); check("R2", "register zero after reset", v, '0);
        end
        rd(3'd4, v);  check("R2", "data read gives pad level", v, 8'h5A);
        check("R2", "no pad driven after reset", pad_oe, '0);
    endtask

    task automatic t_regs();
        logic [N-1:0] v;
        wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h44); wr(3'd3, 8'h88);
        wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd0, v); check("R1", "assign readback", v, 8'h11);
        rd(3'd1, v); check("R1", "option readback", v, 8'h22);
        rd(3'd2, v); check("R1", "direction readback", v, 8'h44);
        rd(3'd3, v); check("R1", "open-drain readback", v, 8'h88);
        rd(3'd6, v); check("R1", "unused address reads zero", v, '0);
        cfg('0, '0, '0, '0, '0);
    endtask

    task automatic t_gpio();
        logic [N-1:0] v;
        pad_in = 8'h00;
        cfg('0, '0, 8'hFF, '0, 8'hC3);
        check("R5", "gpio drive value", pad_out, 8'hC3);
        check("R3", "all outputs enabled", pad_oe, 8'hFF);
        rd(3'd4, v); check("R8", "latched data on outputs", v, 8'hC3);
        wr(3'd2, 8'h0F);
        pad_in = 8'hAA;
        check("R3", "oe follows direction", pad_oe, 8'h0F);
        rd(3'd4, v); check("R8", "mixed latched/live read", v, 8'hA3);
    endtask

    task automatic t_opendrain();
        cfg('0, '0, 8'hFF, 8'hFF, 8'hC3);
        check("R4", "open-drain pad_out low", pad_out, 8'h00);
        check("R4", "open-drain oe only for zero", pad_oe, 8'h3C);
        wr(3'd2, 8'h0F);
        check("R4", "open-drain input pins floating", pad_oe, 8'h0C);
    endtask

    task automatic t_dedicated();
        logic [N-1:0] v;
        func_a_out = 8'h96; func_b_out = 8'h69; pad_in = 8'h5A;
        cfg(8'hFF, 8'hF0, 8'hFF, '0, 8'h00);
        check("R6", "function select by option", pad_out, 8'h66);
        rd(3'd4, v); check("R8", "dedicated pins read live", v, 8'h5A);
        wr(3'd1, 8'hF1);
        check("R9", "one option bit moves one pin", pad_out, 8'h67);
        wr(3'd0, 8'h0F);
        check("R9", "gpio half uses data", pad_out, 8'h07);
    endtask

    task automatic t_inputs();
        cfg(8'hF0, 8'hCC, 8'h10, '0, '0);
        pad_in = 8'h00; #1;
        check("R7", "input A default mix, pads low", func_a_in, 8'h85);
        check("R7", "input B default mix, pads low", func_b_in, 8'h3C);
        pad_in = 8'hFF; #1;
        check("R7", "input A routed bit, pads high", func_a_in, 8'hA5);
        check("R7", "input B routed bits, pads high", func_b_in, 8'hFC);
        cfg('0, 8'hCC, '0, '0, '0);
        pad_in = 8'h5A; #1;
        check("R7", "gpio pins keep A default", func_a_in, DFLT_A);
        check("R7", "gpio pins keep B default", func_b_in, DFLT_B);
    endtask

    initial begin
        pad_in = '0; func_a_out = '0; func_b_out = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_regs();
        t_gpio();
        t_opendrain();
        t_dedicated();
        t_inputs();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual running expected finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule